// File: doc/BRIEF.md
# RTC Time Access Sequencer

This block drives whole-time transfers to a real-time clock device whose registers are four bits wide. The device keeps each time field as BCD, with the units digit and the tens digit in separate registers. The host gives one of three start commands. A read collects every time field and returns it in binary. A set converts binary fields to BCD and writes them. An init checks the device's oscillator-stop flag and, when the flag is set, puts the device back to a known date. The block finishes every operation with a one-cycle done pulse and an error flag.

The block does not handle the serial bit timing. Each register access goes as one request to a lower serial master: address, direction and a write nibble. The lower master answers with an acknowledge and the read nibble. The sequencer drives the device chip-enable itself. It frames every operation with chip-enable, polls the device busy bit with a bounded number of retries, and drops chip-enable for a fixed gap between attempts and at the end of each operation. If more than one start command arrives in the same cycle, init wins over set, and set wins over read.

Top module: `rtc_time_seq`

## Requirements
- R1: After reset, `ce`, `acc_req`, `done` and `error` are all low.
- R2: A read or a set begins with `ce` high. The first access writes 0x4 to the control register at address 0xE. The second access reads address 0xE back. Transfer of time fields starts only when bit 0 (busy) of that read is 0.
- R3: When the busy bit reads 1, `ce` goes low for at least GAP_CYCLES cycles, and then the write/read pair of R2 is repeated. On the (MAX_RETRY+2)-th consecutive busy read the operation aborts with `error` set and no time register is accessed. MAX_RETRY+1 busy reads followed by a clear read still succeed.
- R4: Time registers are visited at addresses 0x0,0x1,0x2,0x3,0x4,0x5,0x8,0x9,0xA,0xB,0xC,0xD, then weekday at 0x6. Within each field the units register (even address) comes before the tens register.
- R5: On a set, each field value v is written as units nibble v mod 10 and tens nibble v div 10. The device month is the host month (0..11) plus 1. The year is taken modulo 100 (host input 0..127).
- R6: On a read, each field is returned as 10×tens + units. The month is returned as the device month minus 1.
- R7: Init reads the control register once. If bit 1 (oscillator stopped) is 0, init ends without any write and without error.
- R8: If bit 1 is 1, init writes 0x0 to address 0x7 and 0x7 to address 0xE. It then reads 0xE until bit 0 is 0, or until POLL_LIMIT reads have been made, and never raises an error for this. After that it performs a set of 00:00:00, day 1, month 0, year 0, weekday 0.
- R9: Every operation ends with `ce` low for at least GAP_CYCLES cycles, followed by a one-cycle `done` pulse. `error` becomes valid with `done` and stays unchanged until the next accepted start command.
- R10: `acc_req` is only high while `ce` is high. `acc_req` keeps its address, direction and data stable until `acc_ack`, and it is low in the cycle after the acknowledge.
- R11: Start commands that arrive while an operation is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_read | input | 1 | Start a whole-time read |
| cmd_set | input | 1 | Start a whole-time set using the set_* fields |
| cmd_init | input | 1 | Start the power-on validity check |
| set_sec | input | 6 | Seconds to write, binary 0..59 |
| set_min | input | 6 | Minutes to write |
| set_hour | input | 5 | Hours to write, 24-hour |
| set_day | input | 5 | Day of month to write, 1..31 |
| set_mon | input | 4 | Month to write, 0..11 |
| set_year | input | 7 | Year to write, reduced modulo 100 |
| set_wday | input | 3 | Weekday to write, 0..6 |
| get_sec | output | 6 | Seconds read |
| get_min | output | 6 | Minutes read |
| get_hour | output | 5 | Hours read |
| get_day | output | 5 | Day of month read |
| get_mon | output | 4 | Month read, 0-based |
| get_year | output | 7 | Two-digit year read |
| get_wday | output | 3 | Weekday read |
| done | output | 1 | One-cycle pulse when an operation ends |
| error | output | 1 | Busy-retry limit exceeded, held until next start |
| ce | output | 1 | Device chip-enable |
| acc_req | output | 1 | Register access request to the serial master |
| acc_we | output | 1 | Access direction, 1 = write |
| acc_addr | output | 4 | Device register address |
| acc_wdata | output | 4 | Write nibble |
| acc_ack | input | 1 | Access complete, one cycle |
| acc_rdata | input | 4 | Read nibble, valid with acc_ack |

## Verification
The bench targets the retry boundary from both sides: 101 busy reads must end in success and 102 must end in an error. An off-by-one counter would fail one of the two, and a design that lets the abort path continue would also touch the time registers. The init poll limit is driven with a device that stays busy, so a design without the limit hangs, and one that counts wrongly moves the 0x4 control write to the wrong position in the access log. Round trips with year above 99, month 11 and the largest values of every field expose a wrong BCD split, a missing month offset and a swapped units/tens order. A second start issued in the middle of a read shows whether the design lets a command slip in and write the device.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CTRL_WR,
    S_CTRL_RD,
    S_RETRY_GAP,
    S_CHK_RD,
    S_IVL_WR,
    S_ADJ_WR,
    S_ADJ_POLL,
    S_XFER,
    S_END_GAP
  } seq_state_t;

  localparam logic [3:0] REG_CTRL = 4'hE;
  localparam logic [3:0] REG_IVL  = 4'h7;
  localparam logic [3:0] CTRL_RUN = 4'h4;
  localparam logic [3:0] CTRL_ADJ = 4'h7;
  localparam int         NSTEP    = 13;
  localparam int         NFIELD   = 7;

  typedef logic [7:0] bcd_t;

  // binary 0..99 to packed BCD {tens, units}
  function automatic bcd_t to_bcd(input logic [6:0] v);
    logic [6:0] t;
    logic [6:0] u;
    t = v / 7'd10;
    u = v - t * 7'd10;
    return {t[3:0], u[3:0]};
  endfunction

  // packed BCD to binary
  function automatic logic [6:0] from_bcd(input bcd_t b);
    return 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
  endfunction

  function automatic logic [6:0] mod100(input logic [6:0] y);
    return (y >= 7'd100) ? y - 7'd100 : y;
  endfunction

  // transfer step to device address: six two-digit fields skip the weekday slot
  function automatic logic [3:0] step_addr(input logic [3:0] s);
    if (s < 4'd6)       return s;
    else if (s < 4'd12) return s + 4'd2;
    else                return 4'd6;
  endfunction

  // transfer step to field index (0 sec .. 5 year, 6 weekday)
  function automatic logic [2:0] step_field(input logic [3:0] s);
    return (s == 4'd12) ? 3'd6 : s[3:1];
  endfunction

endpackage

// File: rtl/rtc_seq_gap.sv
module rtc_seq_gap #(
  parameter int GAP_CYCLES = 140
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic expired
);
  localparam int GW = $clog2(GAP_CYCLES + 1);

  logic [GW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= GW'(GAP_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/rtc_seq_fields.sv
module rtc_seq_fields
  import rtc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       use_default,
  input  logic [5:0] set_sec,
  input  logic [5:0] set_min,
  input  logic [4:0] set_hour,
  input  logic [4:0] set_day,
  input  logic [3:0] set_mon,
  input  logic [6:0] set_year,
  input  logic [2:0] set_wday,
  input  logic [3:0] step,
  input  logic       cap_en,
  input  logic [3:0] cap_nib,
  output logic [3:0] wr_nib,
  output logic [5:0] get_sec,
  output logic [5:0] get_min,
  output logic [4:0] get_hour,
  output logic [4:0] get_day,
  output logic [3:0] get_mon,
  output logic [6:0] get_year,
  output logic [2:0] get_wday
);
  bcd_t       wbuf [NFIELD];
  bcd_t       rbuf [NFIELD];
  logic [6:0] wsrc [NFIELD];
  logic [6:0] dec  [NFIELD];
  logic [2:0] fsel;
  logic       hi_nib;
  logic [6:0] mon_dec;

  assign fsel   = step_field(step);
  assign hi_nib = step[0];

  always_comb begin
    if (use_default) begin
      wsrc[0] = 7'd0;  wsrc[1] = 7'd0; wsrc[2] = 7'd0;
      wsrc[3] = 7'd1;  wsrc[4] = 7'd1; wsrc[5] = 7'd0;
      wsrc[6] = 7'd0;
    end else begin
      wsrc[0] = {1'b0, set_sec};
      wsrc[1] = {1'b0, set_min};
      wsrc[2] = {2'b0, set_hour};
      wsrc[3] = {2'b0, set_day};
      wsrc[4] = 7'(set_mon) + 7'd1;
      wsrc[5] = mod100(set_year);
      wsrc[6] = {4'b0, set_wday};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NFIELD; i++) begin
        wbuf[i] <= '0;
        rbuf[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NFIELD; i++) begin
        if (load) wbuf[i] <= to_bcd(wsrc[i]);
        if (cap_en && fsel == 3'(i)) begin
          if (hi_nib) rbuf[i][7:4] <= cap_nib;
          else        rbuf[i][3:0] <= cap_nib;
        end
      end
    end
  end

  always_comb begin
    wr_nib = hi_nib ? wbuf[fsel][7:4] : wbuf[fsel][3:0];
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_dec
    assign dec[g] = from_bcd(rbuf[g]);
  end

  assign mon_dec  = dec[4] - 7'd1;
  assign get_sec  = dec[0][5:0];
  assign get_min  = dec[1][5:0];
  assign get_hour = dec[2][4:0];
  assign get_day  = dec[3][4:0];
  assign get_mon  = mon_dec[3:0];
  assign get_year = dec[5];
  assign get_wday = dec[6][2:0];
endmodule

// File: rtl/rtc_seq_fsm.sv
module rtc_seq_fsm
  import rtc_seq_pkg::*;
#(
  parameter int MAX_RETRY  = 100,
  parameter int POLL_LIMIT = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_read,
  input  logic       cmd_set,
  input  logic       cmd_init,
  input  logic       acc_ack,
  input  logic [3:0] acc_rdata,
  input  logic       gap_expired,
  input  logic [3:0] wr_nib,
  output logic       ce,
  output logic       acc_req,
  output logic       acc_we,
  output logic [3:0] acc_addr,
  output logic [3:0] acc_wdata,
  output logic       gap_start,
  output logic [3:0] step,
  output logic       cap_en,
  output logic       load,
  output logic       use_default,
  output logic       done,
  output logic       error,
  output logic       start_acc
);
  localparam int         RW        = $clog2(MAX_RETRY + 2) + 1;
  localparam int         PW        = $clog2(POLL_LIMIT + 1) + 1;
  localparam logic [3:0] LAST_STEP = 4'(NSTEP - 1);

  seq_state_t    state;
  logic          ce_q, ack_q, mode_set, err_pend, err_q, done_q;
  logic [RW-1:0] retries;
  logic [PW-1:0] polls;
  logic [3:0]    step_q;

  logic accessing, acc_evt, busy_bit, stop_bit, retry_exhausted, poll_last;

  assign start_acc   = (state == S_IDLE) && (cmd_read || cmd_set || cmd_init);
  assign load        = start_acc;
  assign use_default = cmd_init;

  assign accessing = (state == S_CTRL_WR) || (state == S_CTRL_RD) ||
                     (state == S_CHK_RD)  || (state == S_IVL_WR)  ||
                     (state == S_ADJ_WR)  || (state == S_ADJ_POLL) ||
                     (state == S_XFER);
  assign acc_req   = accessing && !ack_q;
  assign acc_evt   = acc_req && acc_ack;
  assign busy_bit  = acc_rdata[0];
  assign stop_bit  = acc_rdata[1];
  assign retry_exhausted = (retries == RW'(MAX_RETRY + 1));
  assign poll_last       = (polls == PW'(POLL_LIMIT - 1));

  always_comb begin
    acc_we    = 1'b0;
    acc_addr  = REG_CTRL;
    acc_wdata = 4'h0;
    unique case (state)
      S_CTRL_WR: begin acc_we = 1'b1; acc_wdata = CTRL_RUN; end
      S_IVL_WR:  begin acc_we = 1'b1; acc_addr = REG_IVL; end
      S_ADJ_WR:  begin acc_we = 1'b1; acc_wdata = CTRL_ADJ; end
      S_XFER:    begin acc_we = mode_set; acc_addr = step_addr(step_q); acc_wdata = wr_nib; end
      default:   ;
    endcase
  end

  assign gap_start = acc_evt &&
                     ((state == S_CTRL_RD && busy_bit) ||
                      (state == S_CHK_RD  && !stop_bit) ||
                      (state == S_XFER    && step_q == LAST_STEP));
  assign cap_en    = acc_evt && (state == S_XFER) && !mode_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ce_q     <= 1'b0;
      ack_q    <= 1'b0;
      mode_set <= 1'b0;
      err_pend <= 1'b0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      retries  <= '0;
      polls    <= '0;
      step_q   <= '0;
    end else begin
      ack_q  <= acc_ack;
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: if (start_acc) begin
          err_q    <= 1'b0;
          err_pend <= 1'b0;
          retries  <= '0;
          mode_set <= cmd_init || cmd_set;
          ce_q     <= 1'b1;
          state    <= cmd_init ? S_CHK_RD : S_CTRL_WR;
        end
        S_CTRL_WR: if (acc_evt) state <= S_CTRL_RD;
        S_CTRL_RD: if (acc_evt) begin
          if (!busy_bit) begin
            step_q <= '0;
            state  <= S_XFER;
          end else if (retry_exhausted) begin
            err_pend <= 1'b1;
            ce_q     <= 1'b0;
            state    <= S_END_GAP;
          end else begin
            retries <= retries + 1'b1;
            ce_q    <= 1'b0;
            state   <= S_RETRY_GAP;
          end
        end
        S_RETRY_GAP: if (gap_expired) begin
          ce_q  <= 1'b1;
          state <= S_CTRL_WR;
        end
        S_CHK_RD: if (acc_evt) begin
          if (stop_bit) state <= S_IVL_WR;
          else begin
            ce_q  <= 1'b0;
            state <= S_END_GAP;
          end
        end
        S_IVL_WR: if (acc_evt) state <= S_ADJ_WR;
        S_ADJ_WR: if (acc_evt) begin
          polls <= '0;
          state <= S_ADJ_POLL;
        end
        S_ADJ_POLL: if (acc_evt) begin
          if (!busy_bit || poll_last) state <= S_CTRL_WR;
          else                        polls <= polls + 1'b1;
        end
        S_XFER: if (acc_evt) begin
          if (step_q == LAST_STEP) begin
            ce_q  <= 1'b0;
            state <= S_END_GAP;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        S_END_GAP: if (gap_expired) begin
          err_q  <= err_pend;
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ce    = ce_q;
  assign step  = step_q;
  assign done  = done_q;
  assign error = err_q;
endmodule

// File: rtl/rtc_time_seq.sv
module rtc_time_seq #(
  parameter int GAP_CYCLES = 140,
  parameter int MAX_RETRY  = 100,
  parameter int POLL_LIMIT = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_read,
  input  logic       cmd_set,
  input  logic       cmd_init,
  input  logic [5:0] set_sec,
  input  logic [5:0] set_min,
  input  logic [4:0] set_hour,
  input  logic [4:0] set_day,
  input  logic [3:0] set_mon,
  input  logic [6:0] set_year,
  input  logic [2:0] set_wday,
  output logic [5:0] get_sec,
  output logic [5:0] get_min,
  output logic [4:0] get_hour,
  output logic [4:0] get_day,
  output logic [3:0] get_mon,
  output logic [6:0] get_year,
  output logic [2:0] get_wday,
  output logic       done,
  output logic       error,
  output logic       ce,
  output logic       acc_req,
  output logic       acc_we,
  output logic [3:0] acc_addr,
  output logic [3:0] acc_wdata,
  input  logic       acc_ack,
  input  logic [3:0] acc_rdata
);
  logic       gap_start, gap_expired, cap_en, load, use_default, start_acc;
  logic [3:0] step, wr_nib;

  rtc_seq_fsm #(
    .MAX_RETRY (MAX_RETRY),
    .POLL_LIMIT(POLL_LIMIT)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_read   (cmd_read),
    .cmd_set    (cmd_set),
    .cmd_init   (cmd_init),
    .acc_ack    (acc_ack),
    .acc_rdata  (acc_rdata),
    .gap_expired(gap_expired),
    .wr_nib     (wr_nib),
    .ce         (ce),
    .acc_req    (acc_req),
    .acc_we     (acc_we),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .gap_start  (gap_start),
    .step       (step),
    .cap_en     (cap_en),
    .load       (load),
    .use_default(use_default),
    .done       (done),
    .error      (error),
    .start_acc  (start_acc)
  );

  rtc_seq_gap #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (gap_start),
    .expired(gap_expired)
  );

  rtc_seq_fields u_fields (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .use_default(use_default),
    .set_sec    (set_sec),
    .set_min    (set_min),
    .set_hour   (set_hour),
    .set_day    (set_day),
    .set_mon    (set_mon),
    .set_year   (set_year),
    .set_wday   (set_wday),
    .step       (step),
    .cap_en     (cap_en),
    .cap_nib    (acc_rdata),
    .wr_nib     (wr_nib),
    .get_sec    (get_sec),
    .get_min    (get_min),
    .get_hour   (get_hour),
    .get_day    (get_day),
    .get_mon    (get_mon),
    .get_year   (get_year),
    .get_wday   (get_wday)
  );
endmodule

// File: rtl/rtc_time_seq_chk.sv
module rtc_time_seq_chk #(
  parameter int GAP_CYCLES = 140
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce,
  input logic       acc_req,
  input logic       acc_ack,
  input logic       acc_we,
  input logic [3:0] acc_addr,
  input logic [3:0] acc_wdata,
  input logic       done,
  input logic       error,
  input logic       start_acc
);
  localparam int LW = $clog2(GAP_CYCLES + 1) + 1;

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       low_cnt <= LW'(GAP_CYCLES);
    else if (ce)                      low_cnt <= '0;
    else if (low_cnt < LW'(GAP_CYCLES)) low_cnt <= low_cnt + 1'b1;
  end

  p_req_ce_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_req |-> ce);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !acc_ack) |=> (acc_req && $stable(acc_addr) && $stable(acc_we) && $stable(acc_wdata)));

  p_req_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && acc_ack) |=> !acc_req);

  p_retry_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ce) |-> (low_cnt >= LW'(GAP_CYCLES)));

  p_done_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!ce && low_cnt == LW'(GAP_CYCLES)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done);

  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !start_acc) |=> error);
endmodule

bind rtc_time_seq rtc_time_seq_chk #(.GAP_CYCLES(GAP_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce       (ce),
  .acc_req  (acc_req),
  .acc_ack  (acc_ack),
  .acc_we   (acc_we),
  .acc_addr (acc_addr),
  .acc_wdata(acc_wdata),
  .done     (done),
  .error    (error),
  .start_acc(start_acc)
);

// File: tb/test_rtc_time_seq.sv
`timescale 1ns/1ps
module test_rtc_time_seq;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_read, cmd_set, cmd_init;
  logic [5:0] set_sec, set_min;
  logic [4:0] set_hour, set_day;
  logic [3:0] set_mon;
  logic [6:0] set_year;
  logic [2:0] set_wday;
  logic [5:0] get_sec, get_min;
  logic [4:0] get_hour, get_day;
  logic [3:0] get_mon;
  logic [6:0] get_year;
  logic [2:0] get_wday;
  logic       done, error, ce, acc_req, acc_we, acc_ack;
  logic [3:0] acc_addr, acc_wdata, acc_rdata;

  always #2.5 clk = ~clk;

  rtc_time_seq i_rtc_time_seq (.*);

  // device model and access log
  logic [3:0] dev [16];
  int         busy_left = 0;
  bit         xstp = 1'b0;
  int         lat = 1;
  int         nlog = 0;
  logic [8:0] log_e [640];  // {we, addr, data}
  int         n_chk = 0, n_fail = 0;

  localparam int ORDER [13] = '{0, 1, 2, 3, 4, 5, 8, 9, 10, 11, 12, 13, 6};
  // {sec6, min6, hour5, day5, mon4, year7, wday3}
  localparam logic [35:0] VEC [4] = '{
    {6'd0,  6'd0,  5'd0,  5'd1,  4'd0,  7'd0,   3'd0},
    {6'd59, 6'd59, 5'd23, 5'd31, 4'd11, 7'd99,  3'd6},
    {6'd7,  6'd42, 5'd13, 5'd9,  4'd8,  7'd123, 3'd3},
    {6'd30, 6'd5,  5'd20, 5'd28, 4'd1,  7'd70,  3'd2}
  };

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    acc_ack = 1'b0;
    acc_rdata = 4'h0;
    for (int i = 0; i < 16; i++) dev[i] = 4'h0;
    forever begin
      @(negedge clk);
      acc_ack = 1'b0;
      if (acc_req) begin
        repeat (lat) @(negedge clk);
        if (nlog < 640) log_e[nlog] = {acc_we, acc_addr, acc_we ? acc_wdata : 4'h0};
        nlog++;
        if (acc_we) begin
          dev[acc_addr] = acc_wdata;
        end else if (acc_addr == 4'hE) begin
          acc_rdata = {2'b01, xstp, (busy_left > 0)};
          if (busy_left > 0) busy_left--;
        end else begin
          acc_rdata = dev[acc_addr];
        end
        acc_ack = 1'b1;
      end
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic pulse(input int which);
    @(negedge clk);
    cmd_read = (which == 0);
    cmd_set  = (which == 1);
    cmd_init = (which == 2);
    @(negedge clk);
    cmd_read = 1'b0; cmd_set = 1'b0; cmd_init = 1'b0;
  endtask

  task automatic run_op(input int which, output logic e);
    nlog = 0;
    pulse(which);
    forever begin
      @(negedge clk);
      if (done) break;
    end
    e = error;
    chk(ce == 1'b0, "R9", "ce low at done", int'(ce), 0);
  endtask

  function automatic int tens_of(input int v);
    int t = 0;
    while (v >= 10) begin v -= 10; t++; end
    return t;
  endfunction

  function automatic logic [8:0] ent(input bit we, input int a, input int d);
    return {we, 4'(a), 4'(d)};
  endfunction

  task automatic check_dev(input int s, input int mi, input int h, input int d,
                           input int mo_dev, input int y, input int w, input string req);
    int vals [6];
    int bad = 0;
    vals = '{s, mi, h, d, mo_dev, y};
    for (int f = 0; f < 6; f++) begin
      int t = tens_of(vals[f]);
      if (dev[ORDER[2*f]] != 4'(vals[f] - 10*t)) bad++;
      if (dev[ORDER[2*f+1]] != 4'(t)) bad++;
    end
    if (dev[6] != 4'(w)) bad++;
    chk(bad == 0, req, "device nibbles mismatching", bad, 0);
  endtask

  logic e;

  initial begin
    rst_n = 1'b0;
    cmd_read = 1'b0; cmd_set = 1'b0; cmd_init = 1'b0;
    set_sec = '0; set_min = '0; set_hour = '0; set_day = '0;
    set_mon = '0; set_year = '0; set_wday = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({ce, acc_req, done, error} == 4'b0, "R1", "reset outputs", int'({ce, acc_req, done, error}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({ce, acc_req, done, error} == 4'b0, "R1", "idle outputs", int'({ce, acc_req, done, error}), 0);

    // vector table: set then read back, latency alternating
    for (int v = 0; v < 4; v++) begin
      int yr;
      int bad;
      lat = (v % 2 == 0) ? 1 : 4;
      {set_sec, set_min, set_hour, set_day, set_mon, set_year, set_wday} = VEC[v];
      yr = int'(set_year);
      while (yr >= 100) yr -= 100;
      run_op(1, e);
      chk(e == 1'b0, "R3", "set error", int'(e), 0);
      chk(log_e[0] == ent(1, 14, 4), "R2", "first access is control write 0x4", int'(log_e[0]), int'(ent(1, 14, 4)));
      chk(log_e[1][8:4] == 5'h0E, "R2", "second access is control read", int'(log_e[1][8:4]), 14);
      chk(nlog == 15, "R10", "access count of set", nlog, 15);
      bad = 0;
      for (int k = 0; k < 13; k++)
        if (log_e[2+k][8:4] != {1'b1, 4'(ORDER[k])}) bad++;
      chk(bad == 0, "R4", "set visiting order errors", bad, 0);
      check_dev(set_sec, set_min, set_hour, set_day, set_mon + 1, yr, set_wday, "R5");
      run_op(0, e);
      bad = 0;
      for (int k = 0; k < 13; k++)
        if (log_e[2+k][8:4] != {1'b0, 4'(ORDER[k])}) bad++;
      chk(bad == 0 && nlog == 15, "R4", "read visiting order errors", bad, 0);
      chk(get_sec == set_sec && get_min == set_min && get_hour == set_hour && get_day == set_day,
          "R6", "read sec", int'(get_sec), int'(set_sec));
      chk(get_mon == set_mon, "R6", "read month", int'(get_mon), int'(set_mon));
      chk(int'(get_year) == yr && get_wday == set_wday, "R6", "read year", int'(get_year), yr);
    end
    lat = 1;

    // R3: 101 busy reads then clear succeeds
    busy_left = 101;
    run_op(0, e);
    chk(e == 1'b0, "R3", "error after 101 busy", int'(e), 0);
    chk(nlog == 101*2 + 15, "R3", "accesses with 101 busy", nlog, 101*2 + 15);

    // R3: 102 busy reads aborts, no time register touched
    busy_left = 102;
    set_sec = 6'd11;
    run_op(1, e);
    chk(e == 1'b1, "R3", "error after 102 busy", int'(e), 1);
    begin
      int other = 0;
      for (int k = 0; k < nlog; k++) if (log_e[k][7:4] != 4'hE) other++;
      chk(other == 0 && nlog == 204, "R3", "non-control accesses on abort", other, 0);
    end
    chk(dev[0] == 4'h0, "R3", "seconds units untouched", int'(dev[0]), 0);

    // R9: error held until next start
    repeat (50) @(negedge clk);
    chk(error == 1'b1, "R9", "error held", int'(error), 1);
    busy_left = 0;
    run_op(0, e);
    chk(e == 1'b0, "R9", "error cleared by next op", int'(e), 0);

    // R7: init with oscillator flag clear
    xstp = 1'b0;
    run_op(2, e);
    chk(e == 1'b0 && nlog == 1 && log_e[0][8:4] == 5'h0E, "R7", "init clear accesses", nlog, 1);

    // R8: init with flag set, busy for three control reads
    for (int i = 0; i < 16; i++) dev[i] = 4'h9;
    xstp = 1'b1;
    busy_left = 3;
    run_op(2, e);
    chk(e == 1'b0, "R8", "init error", int'(e), 0);
    chk(log_e[1] == ent(1, 7, 0), "R8", "interval write", int'(log_e[1]), int'(ent(1, 7, 0)));
    chk(log_e[2] == ent(1, 14, 7), "R8", "adjust write", int'(log_e[2]), int'(ent(1, 14, 7)));
    chk(log_e[6] == ent(1, 14, 4), "R8", "poll stops at clear", int'(log_e[6]), int'(ent(1, 14, 4)));
    check_dev(0, 0, 0, 1, 1, 0, 0, "R8");
    xstp = 1'b0;
    run_op(0, e);
    chk({get_sec, get_min, get_hour, get_mon, get_year, get_wday} == '0 && get_day == 5'd1,
        "R8", "reset date read back day", int'(get_day), 1);

    // R8: poll limit with a device that stays busy
    xstp = 1'b1;
    busy_left = 200;
    run_op(2, e);
    chk(e == 1'b0, "R8", "poll limit error", int'(e), 0);
    chk(log_e[102][8:4] == 5'h0E && log_e[103] == ent(1, 14, 4), "R8", "run write after poll limit",
        int'(log_e[103]), int'(ent(1, 14, 4)));
    xstp = 1'b0;
    busy_left = 0;

    // R11: start command during an operation is ignored
    lat = 3;
    nlog = 0;
    pulse(0);
    repeat (10) @(negedge clk);
    set_sec = 6'd45;
    pulse(1);
    forever begin
      @(negedge clk);
      if (done) break;
    end
    begin
      int extra = 0;
      int wr = 0;
      repeat (300) @(negedge clk) if (done) extra++;
      for (int k = 1; k < nlog; k++) if (log_e[k][8]) wr++;
      chk(extra == 0, "R11", "extra done pulses", extra, 0);
      chk(wr == 0 && nlog == 15, "R11", "writes from ignored set", wr, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule